// File: doc/BRIEF.md
# Processor status code encoder

This block sits between a processor core's execution pipeline and a 4-bit external debug status port. Each clock, the core reports what the current cycle is doing through a set of event inputs:

- an ordinary instruction begins;
- a taken branch begins;
- a return from exception begins;
- the core has just entered user mode;
- a trigger-pulse or debug-data-write instruction begins;
- exception processing is in progress;
- emulation-mode entry is in progress.

The block turns these events into a single registered status code, one clock after the events are presented.

The trace data serializer asks for a byte-count marker ahead of each block of trace data. The encoder keeps that request pending. It places the marker on the port in the first cycle that would otherwise carry the plain continuation code. The marker occupies that one cycle only, and the pending request is then cleared. The multi-cycle exception and emulation codes are repeated for as long as their level inputs stay high.

Top module: `stat_code_enc`

## Requirements
- R1: After reset the status output is 0x0 and no marker request is pending, so an idle cycle after reset gives 0x0.
- R2: A cycle with no event, no held state and no marker available produces 0x0 (continuation) on the next clock.
- R3: An ordinary instruction start produces 0x1 on the next clock.
- R4: The user-mode entry event produces 0x3 on the next clock.
- R5: A trigger-pulse or debug-data-write start produces 0x4. A marker requested in the same cycle appears on the following continuation cycle, directly after the 0x4.
- R6: A taken-branch start produces 0x5, and a return-from-exception start produces 0x7.
- R7: Every cycle in which exception processing is signalled (and emulation is not) produces 0xC, for as many cycles as the signal is held.
- R8: Every cycle in which emulation entry is signalled produces 0xD. This holds even when exception processing is also signalled.
- R9: Both held codes beat all instruction events. Among the instruction events, the order from highest to lowest is user entry, return from exception, branch, trigger/data-write, ordinary start.
- R10: A marker is driven as 0x8 + L, where L is the 2-bit length field (0..3 meaning 1..4 bytes). It appears only in a cycle that would otherwise give 0x0, it lasts exactly one cycle, and the request is consumed.
- R11: A marker request that cannot be shown stays pending through any number of other codes. A newer request replaces the pending length.
- R12: The reserved codes 0x2 and 0x6 are never driven.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_start | input | 1 | Ordinary instruction begins this cycle |
| ev_branch | input | 1 | Taken branch begins this cycle |
| ev_rte | input | 1 | Return from exception begins this cycle |
| ev_user | input | 1 | Instruction that switched to user mode has completed |
| ev_trig | input | 1 | Trigger-pulse or debug-data-write instruction begins |
| exc_busy | input | 1 | Exception processing in progress (level) |
| emu_busy | input | 1 | Emulation-mode entry in progress (level) |
| mk_req | input | 1 | Serializer asks for a byte-count marker |
| mk_len | input | 2 | Marker length field, bytes minus one |
| status_code | output | 4 | Registered status code |

## Verification
The hardest case to reach is a marker that has to wait: it is requested while exception or emulation codes are being held, or while back-to-back instructions leave no continuation cycle. A second request then arrives before the first one has been shown. Directed sequences hold exception processing for several cycles while issuing two requests of different lengths. They then release it and check that only the later length appears, once. A long biased random run mixes these conditions with every event. A reset in the middle of a pending marker confirms the request is dropped.

// File: rtl/stat_enc_pkg.sv
package stat_enc_pkg;
  localparam int CODE_W   = 4;
  localparam int MK_LEN_W = 2;

  typedef enum logic [CODE_W-1:0] {
    ST_CONT   = 4'h0,
    ST_START  = 4'h1,
    ST_USER   = 4'h3,
    ST_TRIG   = 4'h4,
    ST_BRANCH = 4'h5,
    ST_RTE    = 4'h7,
    ST_MARK   = 4'h8,
    ST_EXC    = 4'hC,
    ST_EMU    = 4'hD
  } st_code_e;

  // marker code = base 0x8 plus length field
  function automatic logic [CODE_W-1:0] marker_code(input logic [MK_LEN_W-1:0] len);
    return ST_MARK | CODE_W'(len);
  endfunction

  function automatic logic is_reserved(input logic [CODE_W-1:0] c);
    return (c == 4'h2) || (c == 4'h6);
  endfunction
endpackage

// File: rtl/stat_event_pick.sv
module stat_event_pick
  import stat_enc_pkg::*;
(
  input  logic              ev_start,
  input  logic              ev_branch,
  input  logic              ev_rte,
  input  logic              ev_user,
  input  logic              ev_trig,
  output logic              pick_valid,
  output logic [CODE_W-1:0] pick_code
);
  // fixed priority among instruction events (R9)
  always_comb begin
    pick_valid = 1'b1;
    if (ev_user)        pick_code = ST_USER;
    else if (ev_rte)    pick_code = ST_RTE;
    else if (ev_branch) pick_code = ST_BRANCH;
    else if (ev_trig)   pick_code = ST_TRIG;
    else if (ev_start)  pick_code = ST_START;
    else begin
      pick_valid = 1'b0;
      pick_code  = ST_CONT;
    end
  end
endmodule

// File: rtl/stat_marker_hold.sv
module stat_marker_hold
  import stat_enc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mk_req,
  input  logic [MK_LEN_W-1:0] mk_len,
  input  logic                take,
  output logic                avail,
  output logic [MK_LEN_W-1:0] avail_len,
  output logic                pend_q
);
  logic [MK_LEN_W-1:0] len_q;

  assign avail     = mk_req | pend_q;
  assign avail_len = mk_req ? mk_len : len_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      len_q  <= '0;
    end else if (take) begin
      pend_q <= 1'b0;
    end else if (mk_req) begin
      pend_q <= 1'b1;
      len_q  <= mk_len;
    end
  end

  // R10: a shown marker is consumed
  a_r10_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !pend_q);
  // R11: a waiting marker keeps its length until shown or replaced
  a_r11_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !take && !mk_req) |=> (pend_q && $stable(len_q)));
endmodule

// File: rtl/stat_code_enc.sv
module stat_code_enc
  import stat_enc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ev_start,
  input  logic                ev_branch,
  input  logic                ev_rte,
  input  logic                ev_user,
  input  logic                ev_trig,
  input  logic                exc_busy,
  input  logic                emu_busy,
  input  logic                mk_req,
  input  logic [MK_LEN_W-1:0] mk_len,
  output logic [CODE_W-1:0]   status_code
);
  logic                pick_valid;
  logic [CODE_W-1:0]   pick_code;
  logic                mk_avail;
  logic [MK_LEN_W-1:0] mk_avail_len;
  logic                mk_pend;
  logic                held;
  logic                mk_take;
  logic [CODE_W-1:0]   code_d;

  stat_event_pick u_pick (
    .ev_start   (ev_start),
    .ev_branch  (ev_branch),
    .ev_rte     (ev_rte),
    .ev_user    (ev_user),
    .ev_trig    (ev_trig),
    .pick_valid (pick_valid),
    .pick_code  (pick_code)
  );

  stat_marker_hold u_mark (
    .clk       (clk),
    .rst_n     (rst_n),
    .mk_req    (mk_req),
    .mk_len    (mk_len),
    .take      (mk_take),
    .avail     (mk_avail),
    .avail_len (mk_avail_len),
    .pend_q    (mk_pend)
  );

  assign held    = emu_busy | exc_busy;
  assign mk_take = !held && !pick_valid && mk_avail;

  always_comb begin
    if (emu_busy)        code_d = ST_EMU;
    else if (exc_busy)   code_d = ST_EXC;
    else if (pick_valid) code_d = pick_code;
    else if (mk_avail)   code_d = marker_code(mk_avail_len);
    else                 code_d = ST_CONT;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_code <= ST_CONT;
    else        status_code <= code_d;
  end

  // R12: reserved codes never appear
  a_r12_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !is_reserved(status_code));
  // R8: emulation code while emulation entry is signalled
  a_r8_emu_hold: assert property (@(posedge clk) disable iff (!rst_n)
    emu_busy |=> status_code == 4'hD);
  // R7: exception code while exception processing is signalled
  a_r7_exc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_busy && !emu_busy) |=> status_code == 4'hC);
  // R10: a taken marker shows as a byte-count code
  a_r10_marker_shown: assert property (@(posedge clk) disable iff (!rst_n)
    mk_take |=> status_code[3:2] == 2'b10);
  // R2: idle cycle gives continuation
  a_r2_idle_cont: assert property (@(posedge clk) disable iff (!rst_n)
    (!held && !pick_valid && !mk_req && !mk_pend) |=> status_code == 4'h0);
endmodule

// File: tb/tb_stat_code_enc.sv
`timescale 1ns/1ps
module tb_stat_code_enc;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_start = 0, ev_branch = 0, ev_rte = 0, ev_user = 0, ev_trig = 0;
  logic       exc_busy = 0, emu_busy = 0, mk_req = 0;
  logic [1:0] mk_len = 0;
  logic [3:0] status_code;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;
  // reference state
  bit m_pend = 0;
  int m_len = 0;

  always #2.5 clk = ~clk;

  stat_code_enc dut (
    .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_branch(ev_branch),
    .ev_rte(ev_rte), .ev_user(ev_user), .ev_trig(ev_trig),
    .exc_busy(exc_busy), .emu_busy(emu_busy), .mk_req(mk_req),
    .mk_len(mk_len), .status_code(status_code)
  );

  function automatic string tag_of(int c);
    if (c == 0) return "R2";
    if (c == 1) return "R3";
    if (c == 3) return "R4";
    if (c == 4) return "R5";
    if (c == 5 || c == 7) return "R6";
    if (c == 12) return "R7";
    if (c == 13) return "R8";
    return "R10";
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: status_code actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle of inputs, advance, compare (called at negedge)
  task automatic step(input bit st, input bit br, input bit rt, input bit us,
                      input bit tr, input bit ex, input bit em, input bit rq,
                      input int ln, input string tag);
    int exp;
    ev_start = st; ev_branch = br; ev_rte = rt; ev_user = us; ev_trig = tr;
    exc_busy = ex; emu_busy = em; mk_req = rq; mk_len = 2'(ln);
    if (em) exp = 13;
    else if (ex) exp = 12;
    else if (us) exp = 3;
    else if (rt) exp = 7;
    else if (br) exp = 5;
    else if (tr) exp = 4;
    else if (st) exp = 1;
    else if (rq || m_pend) exp = 8 + (rq ? ln : m_len);
    else exp = 0;
    if (exp >= 8 && exp <= 11) m_pend = 0;
    else if (rq) begin m_pend = 1; m_len = ln; end
    @(posedge clk);
    @(negedge clk);
    check(tag == "" ? tag_of(exp) : tag, int'(status_code), exp);
    vectors++;
    if (status_code == 4'h2 || status_code == 4'h6) begin
      miscompares++;
      $display("FAIL R12: status_code actual 0x%0h expected non-reserved", status_code);
    end
  endtask

  task automatic idle(input string tag);
    step(0,0,0,0,0,0,0,0,0,tag);
  endtask

  task automatic do_reset();
    rst_n = 0;
    ev_start = 0; ev_branch = 0; ev_rte = 0; ev_user = 0; ev_trig = 0;
    exc_busy = 0; emu_busy = 0; mk_req = 0; mk_len = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    m_pend = 0;
    check("R1", int'(status_code), 0);
    rst_n = 1;
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    idle("R1");
    // single events
    step(1,0,0,0,0,0,0,0,0,"R3");
    idle("R2");
    step(0,0,0,1,0,0,0,0,0,"R4");
    step(0,1,0,0,0,0,0,0,0,"R6");
    step(0,0,1,0,0,0,0,0,0,"R6");
    // data write: 0x4 then marker of 4 bytes then data continuation
    step(0,0,0,0,1,0,0,1,3,"R5");
    idle("R5");
    idle("R10");
    // priority among events
    step(1,1,1,1,1,0,0,0,0,"R9");
    step(1,1,1,0,1,0,0,0,0,"R9");
    step(1,1,0,0,1,0,0,0,0,"R9");
    step(1,0,0,0,1,0,0,0,0,"R9");
    step(1,1,1,1,1,1,0,0,0,"R9");
    step(0,0,0,0,0,1,1,0,0,"R8");
    // marker waiting through exception, replaced by newer request
    step(0,0,0,0,0,1,0,1,1,"R11");
    step(0,0,0,0,0,1,0,0,0,"R7");
    step(0,0,0,0,0,1,0,1,2,"R11");
    step(0,0,0,0,0,1,0,0,0,"R7");
    step(1,0,0,0,0,0,0,0,0,"R11");
    idle("R11");   // expects 0xA
    idle("R10");   // consumed: back to 0x0
    // marker waits through emulation
    step(0,0,0,0,0,0,1,1,0,"R8");
    step(0,0,0,0,0,0,1,0,0,"R8");
    idle("R11");   // expects 0x8
    // marker direct in continuation cycle
    step(0,0,0,0,0,0,0,1,1,"R10");
    idle("R10");
    // reset drops pending marker
    step(0,0,0,0,0,1,0,1,2,"R7");
    do_reset();
    idle("R1");
    // biased random run
    for (int i = 0; i < 4000; i++) begin
      bit ex, em;
      ex = ($urandom % 8) == 0;
      em = ($urandom % 16) == 0;
      step(($urandom % 3) == 0, ($urandom % 8) == 0, ($urandom % 12) == 0,
           ($urandom % 16) == 0, ($urandom % 8) == 0, ex, em,
           ($urandom % 4) == 0, int'($urandom % 4), "");
      if (($urandom % 4) == 0) idle("");
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule